// File: doc/BRIEF.md
# Dual-Output Mode-Decoded Clock Divider

This block derives two clock outputs from one input clock. Each output runs at the input rate, half, a quarter or an eighth of it, or is switched off. The choice comes from decoding three control inputs, each with three levels: a global enable and two selects. Only a sparse set of level combinations is valid; every other combination turns both outputs off. Each output comes with its own output-enable signal. When that signal is deasserted, the output is in the high-impedance state.

Driving the enable low stops and resets the whole block. When the enable leaves the low level, a settle interval follows, counted in input-clock cycles. During it, output 0 is held high. Then both outputs are held low for one cycle, and clocking begins. All divided outputs are taken from one free-running 3-bit counter, so they stay phase-aligned. Changing the mode while the block is enabled never resets that counter.

Top module: `clkdiv_dual`

## Requirements
- R1: While enable is low (code 00), both output-enables are 0 and both outputs are 0 from the next rising input edge on, regardless of the selects.
- R2: Enable low resets the divider counter. After each re-enable, the counter is 0 in the first clocking cycle and counts up by one per rising edge.
- R3: At the first rising edge where enable is not low after being low, a settle phase of SETTLE_CYCLES cycles begins. During it, both output-enables are 1, output 0 is 1 and output 1 is 0. Taking enable low again restarts the settle phase.
- R4: After the settle phase, both outputs are 0 for exactly one cycle with their output-enables at 1, and then clocking begins.
- R5: Control level codes are 00 = low, 01 = mid, 10 = high. The mode (enable, select1, select0) gives the ratio pair (output 0, output 1) as follows:
  - (mid,low,mid) → /1,/1
  - (mid,mid,high) → /1,/2
  - (high,low,low) → /1,/4
  - (mid,low,high) → /2,/2
  - (high,low,high) → /2,/4
  - (mid,low,low) → /4,/4
  - (mid,high,low) → /4,/8
  - (mid,mid,mid) → /8,/1
  - (high,high,low) → /8,/4
  - (high,high,high) → off,/4

  The mode is registered on the rising input edge.
- R6: While clocking, a /2, /4 or /8 output equals bit 0, 1 or 2 of the shared counter.
- R7: A /1 output equals the input clock ANDed with a gate that is updated on the falling input edge. It therefore starts and stops only on whole clock pulses.
- R8: A mode change while enabled does not reset the counter. A newly selected divided output immediately shows the running counter bit.
- R9: Code 11 on any control, and any combination not listed in R5, turns off both outputs during clocking: output-enables 0 and outputs 0.
- R10: A change on enable takes effect only at the next rising input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| en_code | input | 2 | Three-level global enable code |
| s1_code | input | 2 | Three-level select 1 code |
| s0_code | input | 2 | Three-level select 0 code |
| out0 | output | 1 | Output 0 clock level |
| out0_oe | output | 1 | Output 0 drive enable (0 = high impedance) |
| out1 | output | 1 | Output 1 clock level |
| out1_oe | output | 1 | Output 1 drive enable (0 = high impedance) |

## Verification
A counter that is wrong or was not reset shows at the ports as divided outputs with the wrong phase. This appears within one cycle for a /2 output, and within eight cycles for any divided output. A miscounted settle phase moves the high-to-low step on output 0 and the start of clocking by whole cycles. A decode error shows a wrong ratio or a wrong output-enable in the first clocking cycle after the mode is applied. A bad /1 gate shows as a missing or extra clock pulse within one cycle of the gate being switched.

// File: rtl/clkdiv_dual.sv
module clkdiv_dual #(
  parameter int SETTLE_CYCLES = 100
) (
  input  logic       clk_in,
  input  logic [1:0] en_code,
  input  logic [1:0] s1_code,
  input  logic [1:0] s0_code,
  output logic       out0,
  output logic       out0_oe,
  output logic       out1,
  output logic       out1_oe
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [1:0] PH_OFF = 2'd0, PH_SETTLE = 2'd1, PH_LOW = 2'd2, PH_RUN = 2'd3;

  logic [1:0]    phase;
  logic [CW-1:0] settle_cnt;
  logic [2:0]    div;
  logic          on0_q, on1_q, on0_d, on1_d;
  logic [1:0]    r0_q, r1_q, r0_d, r1_d;
  logic          gate0, gate1;
  logic          tap0, tap1;
  logic          en_low;

  assign en_low = (en_code == 2'b00);

  always_comb begin
    case ({en_code, s1_code, s0_code})
      6'b01_00_01: {on0_d, r0_d, on1_d, r1_d} = 6'b100_100;
      6'b01_01_10: {on0_d, r0_d, on1_d, r1_d} = 6'b100_101;
      6'b10_00_00: {on0_d, r0_d, on1_d, r1_d} = 6'b100_110;
      6'b01_00_10: {on0_d, r0_d, on1_d, r1_d} = 6'b101_101;
      6'b10_00_10: {on0_d, r0_d, on1_d, r1_d} = 6'b101_110;
      6'b01_00_00: {on0_d, r0_d, on1_d, r1_d} = 6'b110_110;
      6'b01_10_00: {on0_d, r0_d, on1_d, r1_d} = 6'b110_111;
      6'b01_01_01: {on0_d, r0_d, on1_d, r1_d} = 6'b111_100;
      6'b10_10_00: {on0_d, r0_d, on1_d, r1_d} = 6'b111_110;
      6'b10_10_10: {on0_d, r0_d, on1_d, r1_d} = 6'b000_110;
      default:     {on0_d, r0_d, on1_d, r1_d} = 6'b000_000;
    endcase
  end

  always_ff @(posedge clk_in) begin
    if (en_low) begin
      phase      <= PH_OFF;
      settle_cnt <= '0;
      div        <= '0;
      on0_q      <= 1'b0;
      on1_q      <= 1'b0;
      r0_q       <= 2'd0;
      r1_q       <= 2'd0;
    end else begin
      on0_q <= on0_d;
      on1_q <= on1_d;
      r0_q  <= r0_d;
      r1_q  <= r1_d;
      case (phase)
        PH_OFF: begin
          phase      <= PH_SETTLE;
          settle_cnt <= '0;
        end
        PH_SETTLE: begin
          if (settle_cnt == CW'(SETTLE_CYCLES - 1)) phase <= PH_LOW;
          else settle_cnt <= settle_cnt + 1'b1;
        end
        PH_LOW:  phase <= PH_RUN;
        default: div <= div + 3'd1;
      endcase
    end
  end

  always_ff @(negedge clk_in) begin
    if (en_low) begin
      gate0 <= 1'b0;
      gate1 <= 1'b0;
    end else begin
      gate0 <= (phase == PH_RUN) && on0_q && (r0_q == 2'd0);
      gate1 <= (phase == PH_RUN) && on1_q && (r1_q == 2'd0);
    end
  end

  always_comb begin
    case (r0_q)
      2'd0:    tap0 = clk_in & gate0;
      2'd1:    tap0 = div[0];
      2'd2:    tap0 = div[1];
      default: tap0 = div[2];
    endcase
    case (r1_q)
      2'd0:    tap1 = clk_in & gate1;
      2'd1:    tap1 = div[0];
      2'd2:    tap1 = div[1];
      default: tap1 = div[2];
    endcase
  end

  assign out0    = (phase == PH_SETTLE) || ((phase == PH_RUN) && on0_q && tap0);
  assign out1    = (phase == PH_RUN) && on1_q && tap1;
  assign out0_oe = (phase == PH_SETTLE) || (phase == PH_LOW) || ((phase == PH_RUN) && on0_q);
  assign out1_oe = (phase == PH_SETTLE) || (phase == PH_LOW) || ((phase == PH_RUN) && on1_q);
endmodule

// File: rtl/clkdiv_dual_chk.sv
module clkdiv_dual_chk (
  input logic       clk_in,
  input logic [1:0] en_code,
  input logic [1:0] s1_code,
  input logic [1:0] s0_code,
  input logic [1:0] phase,
  input logic [1:0] r0,
  input logic       out0,
  input logic       out0_oe,
  input logic       out1,
  input logic       out1_oe
);
  logic seen;
  initial seen = 1'b0;
  always @(posedge clk_in) seen <= 1'b1;

  a_r1_disabled_hiz: assert property (@(posedge clk_in) disable iff (!seen)
    $past(en_code) == 2'b00 |-> !out0_oe && !out1_oe && !out0 && !out1);

  a_r3_settle_drive: assert property (@(posedge clk_in) disable iff (!seen)
    ($past(en_code) == 2'b00 && en_code != 2'b00) |=> out0_oe && out0 && out1_oe && !out1);

  a_r4_low_gap: assert property (@(posedge clk_in) disable iff (!seen)
    ($past(phase) == 2'd1 && phase == 2'd2) |-> !out0 && !out1 && out0_oe && out1_oe);

  a_r6_div2_alternates: assert property (@(posedge clk_in) disable iff (!seen)
    (phase == 2'd3 && $past(phase) == 2'd3 && r0 == 2'd1 && $past(r0) == 2'd1 &&
     out0_oe && $past(out0_oe)) |-> out0 != $past(out0));

  a_r9_bad_code_off: assert property (@(posedge clk_in) disable iff (!seen)
    (phase == 2'd3 && $past(en_code) != 2'b00 &&
     $past(s0_code == 2'b11 || s1_code == 2'b11)) |-> !out0_oe && !out1_oe);
endmodule

bind clkdiv_dual clkdiv_dual_chk u_chk (
  .clk_in(clk_in), .en_code(en_code), .s1_code(s1_code), .s0_code(s0_code),
  .phase(phase), .r0(r0_q), .out0(out0), .out0_oe(out0_oe), .out1(out1), .out1_oe(out1_oe)
);

// File: tb/clkdiv_dual_tb.sv
`timescale 1ns/1ps
module clkdiv_dual_tb;
  localparam int S = 100;
  logic clk = 1'b0;
  logic [1:0] en = 2'b00, s1 = 2'b00, s0 = 2'b00;
  logic o0, o0e, o1, o1e;
  int checks = 0, errors = 0, cycles = 0;

  int age = -1;
  int last_chg = -100;
  logic [5:0] m = 6'd0;
  logic g0 = 1'b0, g1 = 1'b0;

  clkdiv_dual #(.SETTLE_CYCLES(S)) u_dut (
    .clk_in(clk), .en_code(en), .s1_code(s1), .s0_code(s0),
    .out0(o0), .out0_oe(o0e), .out1(o1), .out1_oe(o1e));

  always #2 clk = ~clk;

  function automatic logic [5:0] ref_dec(input logic [1:0] e, input logic [1:0] a, input logic [1:0] b);
    int key;
    if (e == 2'b00 || e == 2'b11 || a == 2'b11 || b == 2'b11) return 6'd0;
    key = int'(e) * 9 + int'(a) * 3 + int'(b);
    case (key)
      10: return 6'b100_100;
      14: return 6'b100_101;
      18: return 6'b100_110;
      11: return 6'b101_101;
      20: return 6'b101_110;
      9:  return 6'b110_110;
      15: return 6'b110_111;
      13: return 6'b111_100;
      24: return 6'b111_110;
      26: return 6'b000_110;
      default: return 6'd0;
    endcase
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, got, exp);
    end
  endtask

  function automatic logic run_out(input logic on, input logic [1:0] r, input logic g, input int d);
    if (!on) return 1'b0;
    if (r == 2'd0) return g;
    return 1'((d >> (int'(r) - 1)) & 1);
  endfunction

  always @(posedge clk) begin
    logic [5:0] nm;
    int d;
    cycles++;
    if (en == 2'b00) begin
      age = -1;
      m = 6'd0;
    end else begin
      age++;
      nm = ref_dec(en, s1, s0);
      if (nm != m && age > S + 1) last_chg = age;
      m = nm;
    end
    #1;
    if (age < 0) begin
      chk(o0e, 1'b0, "R1 out0_oe"); chk(o1e, 1'b0, "R1 out1_oe");
      chk(o0, 1'b0, "R1 out0");     chk(o1, 1'b0, "R1 out1");
    end else if (age < S) begin
      chk(o0e, 1'b1, "R3 out0_oe"); chk(o1e, 1'b1, "R3 out1_oe");
      chk(o0, 1'b1, "R3 out0");     chk(o1, 1'b0, "R3 out1");
    end else if (age == S) begin
      chk(o0e, 1'b1, "R4 out0_oe"); chk(o1e, 1'b1, "R4 out1_oe");
      chk(o0, 1'b0, "R4 out0");     chk(o1, 1'b0, "R4 out1");
    end else begin
      d = (age - S - 1) % 8;
      if (m == 6'd0) begin
        chk(o0e, 1'b0, "R9 out0_oe"); chk(o1e, 1'b0, "R9 out1_oe");
        chk(o0, 1'b0, "R9 out0");     chk(o1, 1'b0, "R9 out1");
      end else begin
        chk(o0e, m[5], "R5 out0_oe"); chk(o1e, m[2], "R5 out1_oe");
        if (age <= S + 2)
          chk(o0, run_out(m[5], m[4:3], g0, d), "R2 out0 after restart");
        else if (age - last_chg < 8)
          chk(o1, run_out(m[2], m[1:0], g1, d), "R8 out1 after mode change");
        if (m[4:3] == 2'd0) chk(o0, run_out(m[5], m[4:3], g0, d), "R7 out0");
        else                chk(o0, run_out(m[5], m[4:3], g0, d), "R6 out0");
        if (m[1:0] == 2'd0) chk(o1, run_out(m[2], m[1:0], g1, d), "R7 out1");
        else                chk(o1, run_out(m[2], m[1:0], g1, d), "R6 out1");
      end
    end
  end

  always @(negedge clk) begin
    g0 = (en != 2'b00) && (age > S) && m[5] && (m[4:3] == 2'd0);
    g1 = (en != 2'b00) && (age > S) && m[2] && (m[1:0] == 2'd0);
  end

  task automatic apply(input logic [5:0] c, input int n);
    @(posedge clk); #1.5;
    {en, s1, s0} = c;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    logic [5:0] modes [10];
    modes = '{6'b01_00_01, 6'b01_01_10, 6'b10_00_00, 6'b01_00_10, 6'b10_00_10,
              6'b01_00_00, 6'b01_10_00, 6'b01_01_01, 6'b10_10_00, 6'b10_10_10};
    apply(6'b00_01_01, 5);
    apply(6'b01_00_10, S + 30);
    apply(6'b01_10_00, 30);
    for (int i = 0; i < 10; i++) apply(modes[i], 20);
    apply(6'b01_00_11, 15);
    apply(6'b01_11_00, 15);
    apply(6'b10_01_01, 15);
    apply(6'b01_00_10, 10);
    @(posedge clk); #1.5;
    en = 2'b00;
    #1;
    chk(o0e, 1'b1, "R10 out0_oe held until edge");
    repeat (5) @(posedge clk);
    apply(6'b01_00_10, 40);
    apply(6'b00_00_10, 1);
    apply(6'b01_00_10, S + 40);
    apply(6'b00_00_00, 3);
    @(posedge clk); #1.5;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule